// File: doc/BRIEF.md
# UART FIFO Control with DMA Ready Signaling

This block is the FIFO control logic for one UART channel. It keeps a transmit queue and a receive queue, each 16 bytes deep and 8 bits wide. An 8-bit control register sets how both queues run. The surrounding channel pushes bytes into the transmit queue from the host side and pops them toward the transmit shift register. It pushes bytes from the receive shift register into the receive queue, and the host pops them. A receive time-out pulse comes from an external counter.

The control register does four things. It switches the queues between full depth and single-byte holding operation. It flushes either queue with a one-shot command. It picks one of two DMA signaling styles. It sets the receive threshold, which is 1, 4, 8 or 14 bytes. Two active-low ready outputs tell a DMA engine when to service the channel. The receive ready signal reaches a multi-function pin only when an alternate-function select routes it there. Otherwise that pin carries an alternate input.

The receive ready output in mode 1 comes from a two-state machine. `RR_IDLE` drives the signal inactive (high). `RR_ACTIVE` drives it active (low). There are three transitions. *Arm* goes from `RR_IDLE` to `RR_ACTIVE` when the occupancy is at or above the threshold, or when a time-out arrives while data is queued. *Release* goes from `RR_ACTIVE` to `RR_IDLE` when the receive queue is empty. *Abort* goes from either state to `RR_IDLE` whenever mode 1 is not in force. Each state holds in every other case.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are disabled, mode 0 is selected and the threshold code is 00. A control write with bit 0 = 0 disables the queues. In that write, bits 1, 2, 3 and 7:6 have no effect.
- R2: A control write with bit 0 = 1 and bit 1 = 1 empties the receive queue and clears the receive overrun flag, both visible one cycle after the write. The command needs no later write to clear it.
- R3: A control write with bit 0 = 1 and bit 2 = 1 empties the transmit queue, visible one cycle after the write. The receive queue is left as it was.
- R4: Control bits 7:6, written with bit 0 = 1, set the receive threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14 bytes.
- R5: In mode 1 (queues enabled, and bit 3 = 1 in the last write that had bit 0 = 1), tx_rdy_n is 1 exactly when the transmit queue holds 16 bytes, and 0 otherwise.
- R6: In mode 1 the receive ready signal goes low one clock edge after the receive occupancy is at or above the threshold. It also goes low one edge after a time-out pulse that arrives while the occupancy is nonzero.
- R7: In mode 1, once receive ready is low, it stays low while any byte remains, even below the threshold. It returns high one edge after the occupancy reaches 0.
- R8: mf_out equals the receive ready signal while alt_sel = 1, and equals alt_in while alt_sel = 0.
- R9: Outside mode 1, tx_rdy_n is 0 exactly when the transmit queue is empty. Receive ready is 0 exactly when at least one received byte is queued.
- R10: A push into a full queue is dropped. A dropped receive push sets rx_overrun, which stays 1 until reset or a receive flush.
- R11: A pop from an empty queue leaves the read data and the occupancy unchanged.
- R12: While disabled, each queue holds at most 1 byte. Any write that changes bit 0's enabled state empties both queues.
- R13: Bytes leave each queue in the order they entered. The read data is updated at the clock edge that accepts the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| rx_timeout | input | 1 | Receive time-out pulse from the external counter |
| alt_sel | input | 1 | Routes receive ready to mf_out when 1 |
| alt_in | input | 1 | Alternate function shown on mf_out when alt_sel is 0 |
| tx_rdy_n | output | 1 | Active-low transmit DMA ready |
| mf_out | output | 1 | Multi-function pin: receive ready or alt_in |
| rx_overrun | output | 1 | Sticky flag for a dropped receive push |
| tx_count | output | 5 | Transmit queue occupancy |
| rx_count | output | 5 | Receive queue occupancy |

## Verification
The bench targets five corner cases.

First, receive ready must hold through the drain below the threshold and release only one edge after the queue is empty. A version without this hysteresis would drop the signal as soon as occupancy fell under the threshold. Second, the threshold codes are checked one below and at the 14-byte level. A version with swapped encodings would assert ready too early or too late.

Third, control writes with bit 0 cleared are checked in both directions. A version that did not gate those writes would switch modes or flush queues on them. A version that did not flush on an enable change would leave stale bytes beyond the one-byte holding depth. Fourth, pushes into full queues and pops from empty ones are checked. A wrong design would overwrite data, move occupancy, or lose the sticky overrun flag.

Fifth, time-out pulses arrive both with data queued and with an empty queue. Only the first case may assert receive ready.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // control register bit positions (the write decoder depends on them)
    localparam int CTL_EN      = 0;
    localparam int CTL_RXCLR   = 1;
    localparam int CTL_TXCLR   = 2;
    localparam int CTL_DMA     = 3;
    localparam int CTL_TRIG_LO = 6;
    localparam int CTL_TRIG_HI = 7;

    // index of each direction in the queue array
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int NDIR   = 2;

    typedef enum logic {
        RR_IDLE   = 1'b0,
        RR_ACTIVE = 1'b1
    } rr_state_e;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic       dma_mode,
    output logic [1:0] trig_sel,
    output logic       rx_clr,
    output logic       tx_clr
);
    timeunit 1ns;
    timeprecision 1ps;

    logic       en_q;
    logic       dma_q;
    logic [1:0] trig_q;
    logic       en_change;
    logic       ctl_unused;

    assign ctl_unused = ^wdata[5:4];

    // A write that flips the enable state flushes both queues. Flush
    // commands are one-shot pulses taken from the write itself.
    assign en_change = we && (wdata[CTL_EN] != en_q);
    assign rx_clr    = en_change || (we && wdata[CTL_EN] && wdata[CTL_RXCLR]);
    assign tx_clr    = en_change || (we && wdata[CTL_EN] && wdata[CTL_TXCLR]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            dma_q  <= 1'b0;
            trig_q <= 2'b00;
        end else if (we) begin
            en_q <= wdata[CTL_EN];
            if (wdata[CTL_EN]) begin
                dma_q  <= wdata[CTL_DMA];
                trig_q <= wdata[CTL_TRIG_HI:CTL_TRIG_LO];
            end
        end
    end

    assign fifo_en  = en_q;
    assign dma_mode = dma_q;
    assign trig_sel = trig_q;

    AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[CTL_EN]) |=> (dma_q == $past(dma_q) && trig_q == $past(trig_q) && !en_q)); // R1
endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          one_deep,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          drop
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cap;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = one_deep ? CW'(1) : CW'(DEPTH);
    assign full    = (cnt_q >= cap);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign drop    = push && full && !clr;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            rdata  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
                rdata  <= mem[rd_ptr];
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R13
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (cnt_q == $past(cnt_q))); // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> ($stable(rdata) && cnt_q == '0)); // R11
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R2
    AST_ONE_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        one_deep |-> (cnt_q <= CW'(1))); // R12
endmodule

// File: rtl/ufc_rx_ready.sv
module ufc_rx_ready
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode1,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] rx_count,
    input  logic          timeout,
    output logic          rx_rdy_n
);
    timeunit 1ns;
    timeprecision 1ps;

    rr_state_e     state_q;
    rr_state_e     state_d;
    logic [CW-1:0] trig_cnt;
    logic          have_data;
    logic          arm;

    assign trig_cnt  = CW'(trig_level(trig_sel));
    assign have_data = (rx_count != '0);
    assign arm       = (rx_count >= trig_cnt) || (timeout && have_data);

    always_comb begin
        state_d = state_q;
        if (!mode1) begin
            state_d = RR_IDLE;                    // abort
        end else begin
            unique case (state_q)
                RR_IDLE:   if (arm)        state_d = RR_ACTIVE; // arm
                RR_ACTIVE: if (!have_data) state_d = RR_IDLE;   // release
                default:   state_d = RR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (mode1) begin
            rx_rdy_n = (state_q != RR_ACTIVE);
        end else begin
            rx_rdy_n = !have_data;
        end
    end

    AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RR_ACTIVE && mode1 && have_data) |=> (state_q == RR_ACTIVE)); // R7
    AST_RR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RR_ACTIVE && !have_data) |=> (state_q == RR_IDLE)); // R7
    AST_RR_NO_EMPTY_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RR_IDLE && !have_data) |=> (state_q == RR_IDLE)); // R6
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              rx_timeout,
    input  logic              alt_sel,
    input  logic              alt_in,
    output logic              tx_rdy_n,
    output logic              mf_out,
    output logic              rx_overrun,
    output logic [CW-1:0]     tx_count,
    output logic [CW-1:0]     rx_count
);
    timeunit 1ns;
    timeprecision 1ps;

    logic       fifo_en;
    logic       dma_mode;
    logic [1:0] trig_sel;
    logic       rx_clr;
    logic       tx_clr;
    logic       mode1;
    logic       rx_rdy_n;
    logic       ovr_q;

    logic              q_clr   [NDIR];
    logic              q_push  [NDIR];
    logic [DATA_W-1:0] q_wdata [NDIR];
    logic              q_pop   [NDIR];
    logic [DATA_W-1:0] q_rdata [NDIR];
    logic [CW-1:0]     q_count [NDIR];
    logic              q_full  [NDIR];
    logic              q_empty [NDIR];
    logic              q_drop  [NDIR];

    ufc_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .trig_sel (trig_sel),
        .rx_clr   (rx_clr),
        .tx_clr   (tx_clr)
    );

    assign mode1 = fifo_en && dma_mode;

    assign q_clr[DIR_TX]   = tx_clr;
    assign q_push[DIR_TX]  = tx_push;
    assign q_wdata[DIR_TX] = tx_wdata;
    assign q_pop[DIR_TX]   = tx_pop;
    assign q_clr[DIR_RX]   = rx_clr;
    assign q_push[DIR_RX]  = rx_push;
    assign q_wdata[DIR_RX] = rx_wdata;
    assign q_pop[DIR_RX]   = rx_pop;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ufc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (q_clr[d]),
            .one_deep (!fifo_en),
            .push     (q_push[d]),
            .wdata    (q_wdata[d]),
            .pop      (q_pop[d]),
            .rdata    (q_rdata[d]),
            .count    (q_count[d]),
            .full     (q_full[d]),
            .empty    (q_empty[d]),
            .drop     (q_drop[d])
        );
    end

    ufc_rx_ready #(.CW(CW)) u_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode1    (mode1),
        .trig_sel (trig_sel),
        .rx_count (q_count[DIR_RX]),
        .timeout  (rx_timeout),
        .rx_rdy_n (rx_rdy_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (rx_clr) begin
            ovr_q <= 1'b0;
        end else if (q_drop[DIR_RX]) begin
            ovr_q <= 1'b1;
        end
    end

    always_comb begin
        if (mode1) begin
            tx_rdy_n = q_full[DIR_TX];
        end else begin
            tx_rdy_n = !q_empty[DIR_TX];
        end
        mf_out = alt_sel ? rx_rdy_n : alt_in;
    end

    assign tx_rdata   = q_rdata[DIR_TX];
    assign rx_rdata   = q_rdata[DIR_RX];
    assign tx_count   = q_count[DIR_TX];
    assign rx_count   = q_count[DIR_RX];
    assign rx_overrun = ovr_q;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !rx_clr) |=> ovr_q); // R10
    AST_TXCLR_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !rx_clr && !rx_push && !rx_pop) |=> $stable(rx_count)); // R3
endmodule

// File: tb/uart_fifo_ctl_test.sv
module uart_fifo_ctl_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic       rx_timeout = 1'b0, alt_sel = 1'b1, alt_in = 1'b0;
    logic [7:0] tx_rdata, rx_rdata;
    logic       tx_rdy_n, mf_out, rx_overrun;
    logic [4:0] tx_count, rx_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // model state
    byte unsigned tq[$];
    byte unsigned rq[$];
    bit           m_en, m_dma, m_ract, m_ovr;
    bit [1:0]     m_trig;
    byte unsigned m_tdat, m_rdat;

    uart_fifo_ctl uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_timeout(rx_timeout), .alt_sel(alt_sel), .alt_in(alt_in),
        .tx_rdy_n(tx_rdy_n), .mf_out(mf_out), .rx_overrun(rx_overrun),
        .tx_count(tx_count), .rx_count(rx_count)
    );

    always #10 clk = ~clk; // 20 ns period, 50 MHz

    function automatic int thr(input bit [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit exp_rr();
        if (m_en && m_dma) return !m_ract;
        return (rq.size() == 0);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // advance the model across one clock edge using the applied inputs
    task automatic model_step();
        bit clr_r, clr_t, m1, pop_ok, push_ok;
        int rcnt;
        clr_r = 0; clr_t = 0;
        m1 = m_en && m_dma;
        rcnt = rq.size();
        // receive ready state machine, from pre-edge state
        if (!m1) m_ract = 0;
        else if (!m_ract) m_ract = (rcnt >= thr(m_trig)) || (rx_timeout && rcnt != 0);
        else if (rcnt == 0) m_ract = 0;
        // FIFOs use pre-edge depth
        if (ctl_we) begin
            if (ctl_wdata[0] != m_en) begin clr_r = 1; clr_t = 1; end
            if (ctl_wdata[0]) begin
                clr_r |= ctl_wdata[1];
                clr_t |= ctl_wdata[2];
            end
        end
        if (clr_t) tq.delete();
        else begin
            pop_ok  = tx_pop && tq.size() > 0;
            push_ok = tx_push && tq.size() < (m_en ? 16 : 1);
            if (pop_ok) m_tdat = tq.pop_front();
            if (push_ok) tq.push_back(tx_wdata);
        end
        if (clr_r) begin rq.delete(); m_ovr = 0; end
        else begin
            pop_ok  = rx_pop && rq.size() > 0;
            push_ok = rx_push && rq.size() < (m_en ? 16 : 1);
            if (rx_push && !push_ok) m_ovr = 1;
            if (pop_ok) m_rdat = rq.pop_front();
            if (push_ok) rq.push_back(rx_wdata);
        end
        if (ctl_we) begin
            m_en = ctl_wdata[0];
            if (ctl_wdata[0]) begin m_dma = ctl_wdata[3]; m_trig = ctl_wdata[7:6]; end
        end
    endtask

    task automatic check_all();
        bit m1;
        m1 = m_en && m_dma;
        check(m1 ? "R5" : "R9", "tx_rdy_n", tx_rdy_n, m1 ? int'(tq.size() == 16) : int'(tq.size() != 0));
        if (alt_sel) check(m1 ? "R7" : "R9", "rx ready", mf_out, exp_rr());
        check("R8", "mf_out", mf_out, alt_sel ? exp_rr() : alt_in);
        check("R13", "tx_count", tx_count, tq.size());
        check("R13", "rx_count", rx_count, rq.size());
        check("R13", "tx_rdata", tx_rdata, m_tdat);
        check("R11", "rx_rdata", rx_rdata, m_rdat);
        check("R10", "rx_overrun", rx_overrun, m_ovr);
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        check_all();
        ctl_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; rx_timeout = 0;
    endtask

    task automatic wr(input logic [7:0] v);
        ctl_we = 1; ctl_wdata = v; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        byte unsigned keep;
        int pp, qp;
        void'($urandom(32'h5EED_0C17));
        m_en = 0; m_dma = 0; m_ract = 0; m_ovr = 0; m_trig = 0; m_tdat = 0; m_rdat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset tx_count", tx_count, 0);
        check("R1", "reset tx_rdy_n", tx_rdy_n, 0);
        check("R1", "reset rx ready", mf_out, 1);
        check_all();

        // R1: gated write with bit0 = 0 must not set mode 1 or flush
        wr(8'h0E);
        rx_push = 1; rx_wdata = 8'h11; tick();
        check("R1", "mode0 rx ready after gated write", mf_out, 0);
        rx_push = 1; rx_wdata = 8'h22; tick();
        check("R12", "one-deep rx_count", rx_count, 1);
        check("R10", "overrun after drop", rx_overrun, 1);
        rx_pop = 1; tick();
        check("R13", "held byte", rx_rdata, 8'h11);

        // enable, mode 1, threshold 14: enable change flushes (R12)
        rx_push = 1; rx_wdata = 8'h33; tick();
        wr(8'hC9);
        check("R12", "flush on enable rx_count", rx_count, 0);
        check("R2", "overrun cleared by flush", rx_overrun, 0);
        for (int i = 0; i < 13; i++) begin rx_push = 1; rx_wdata = 8'(i + 1); tick(); end
        tick();
        check("R4", "13 below threshold 14", mf_out, 1);
        rx_push = 1; rx_wdata = 8'd14; tick();
        check("R4", "edge of reaching 14", mf_out, 1);
        tick();
        check("R6", "ready after 14", mf_out, 0);
        for (int i = 0; i < 13; i++) begin rx_pop = 1; tick(); end
        check("R7", "hold with 1 byte", mf_out, 0);
        rx_pop = 1; tick();
        check("R7", "edge of empty", mf_out, 0);
        tick();
        check("R7", "released", mf_out, 1);

        // R5 transmit full
        for (int i = 0; i < 16; i++) begin
            tx_push = 1; tx_wdata = 8'(8'hA0 + i); tick();
            if (i == 14) check("R5", "15 bytes", tx_rdy_n, 0);
        end
        check("R5", "16 bytes full", tx_rdy_n, 1);
        tx_push = 1; tx_wdata = 8'hFF; tick();
        check("R10", "tx full drop", tx_count, 16);
        tx_pop = 1; tick();
        check("R13", "tx first out", tx_rdata, 8'hA0);
        check("R5", "15 after pop", tx_rdy_n, 0);

        // R3 transmit flush, receive kept
        rx_push = 1; rx_wdata = 8'h5A; tick();
        wr(8'hCD);
        check("R3", "tx flushed", tx_count, 0);
        check("R3", "rx kept", rx_count, 1);
        // R2 receive flush
        rx_push = 1; rx_wdata = 8'h5B; tick();
        wr(8'hCB);
        check("R2", "rx flushed", rx_count, 0);
        keep = rx_rdata;
        rx_pop = 1; tick();
        check("R11", "empty pop keeps data", rx_rdata, keep);
        check("R11", "empty pop count", rx_count, 0);

        // R6 time-out: empty queue ignored, with data arms
        rx_timeout = 1; tick(); tick();
        check("R6", "timeout on empty", mf_out, 1);
        rx_push = 1; rx_wdata = 8'h77; tick(); tick();
        check("R6", "1 byte below 14", mf_out, 1);
        rx_timeout = 1; tick();
        check("R6", "timeout arms", mf_out, 0);
        alt_sel = 0; alt_in = 1; tick();
        check("R8", "alt routed", mf_out, 1);
        alt_sel = 1; tick();

        // constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            case ((i / 500) % 4)
                0: begin pp = 70; qp = 30; end
                1: begin pp = 30; qp = 70; end
                2: begin pp = 90; qp = 10; end
                default: begin pp = 50; qp = 50; end
            endcase
            tx_push = ($urandom % 100) < pp; tx_wdata = 8'($urandom);
            tx_pop  = ($urandom % 100) < qp;
            rx_push = ($urandom % 100) < pp; rx_wdata = 8'($urandom);
            rx_pop  = ($urandom % 100) < qp;
            rx_timeout = ($urandom % 30) == 0;
            if (($urandom % 50) == 0) alt_sel = ~alt_sel;
            alt_in = 1'($urandom);
            if (($urandom % 80) == 0) begin
                ctl_we = 1;
                ctl_wdata = 8'($urandom);
                ctl_wdata[0] = ($urandom % 8) != 0;
            end
            tick();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule